// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the bus-side register file and initialization sequencer of an eight-input programmable interrupt controller. A processor reaches it through a one-bit address, an 8-bit write path, an 8-bit read path and separate write and read strobes. Writes are sorted by address and bit pattern into initialization words, the mask register, two operation words and a command byte. Reads return the mask, request or in-service register, or the result of a poll.

The block holds the request, in-service and mask registers and the configuration words. It exports all of them to the priority resolver and the acknowledge sequencer, which are separate blocks. The priority resolver sends back its current winner (`pendValid`, `pendLevel`). That input is used to answer a poll read and to acknowledge the winner on the spot.

A per-input trigger-mode register is included. When it is switched on with `elcrOn`, each input is edge- or level-triggered on its own bit. When it is off, one bit of the first initialization word selects the mode for all eight inputs.

Top module: `irq_prog_port`

## Requirements
- R1: Synchronous active-high reset clears the request, in-service and mask registers, every configuration word and the special-mask flag, and leaves the sequencer idle (`initBusy` = 0).
- R2: A write with address 0 and data bit 4 set starts initialization and sets `initBusy`. It clears the mask, in-service, second and third initialization words, the operation word and the special-mask flag. It loads the request register with `irqLines`. It clears the fourth word only when data bit 0 of this write is 0. `initStb` pulses in that cycle.
- R3: After the second initialization word, the sequencer waits for the third word only when bit 1 of the first word is 0. Otherwise, and after the third word, it waits for the fourth word when bit 0 of the first word is 1, or returns to idle. After the fourth word it returns to idle. The words appear on `vecBase`, `cascMap` and `modeWord`.
- R4: An address-1 write loads the mask register only while idle. During initialization it loads the expected word and leaves the mask unchanged.
- R5: An address-0 write with bit 4 clear and bit 3 set is stored as the operation word. When its bit 6 is 1, `specialMask` takes its bit 5. When bit 6 is 0, `specialMask` keeps its value.
- R6: An address-0 write with bits 4 and 3 clear raises `cmdStb` in that cycle, with the byte on `cmdByte`. The mask register does not change.
- R7: A read while the operation word's poll bit (bit 2) is set returns 0x80 OR the winning level when `pendValid` is 1. It sets that level's in-service bit, pulses `pollAck`, and clears the request bit of an edge-triggered level. With no winner it returns 0x00 and changes nothing. In both cases the poll bit is cleared after the read.
- R8: A poll acknowledge of a level-triggered input whose line is still high leaves its request bit set.
- R9: Without poll, an address-1 read returns the mask. An address-0 read returns the in-service register when operation-word bits 1:0 are 11, the request register when they are 10, and 0x00 otherwise.
- R10: With the default `PCI_STRICT` = 1, an initialization-start write with any of data bits 7:5 set is ignored.
- R11: The trigger-mode register is written through `elcrWr` with `elcrData`. On the default master variant, bits 2:0 are forced to 0. On the slave variant, bits 0 and 5 are forced to 0.
- R12: `levelTrig` equals the trigger-mode register when `elcrOn` is 1. Otherwise all eight bits copy bit 3 of the first initialization word.
- R13: Outside initialization-start writes, `reqSet` bits set request bits and `isrClr` bits clear in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrStb | input | 1 | Bus write strobe |
| rdStb | input | 1 | Bus read strobe |
| addr | input | 1 | Register address bit |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid while rdStb is high |
| irqLines | input | 8 | Current interrupt line levels |
| reqSet | input | 8 | Request bits to set, from edge/level detection |
| isrClr | input | 8 | In-service bits to clear, from end-of-interrupt logic |
| pendValid | input | 1 | Priority resolver has a winner |
| pendLevel | input | 3 | Winning level |
| elcrOn | input | 1 | Use per-input trigger-mode register |
| elcrWr | input | 1 | Trigger-mode register write strobe |
| elcrData | input | 8 | Trigger-mode register write data |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| initWord | output | 8 | First initialization word |
| vecBase | output | 8 | Second initialization word |
| cascMap | output | 8 | Third initialization word |
| modeWord | output | 8 | Fourth initialization word |
| specialMask | output | 1 | Special-mask mode flag |
| levelTrig | output | 8 | Effective level-trigger select per input |
| initBusy | output | 1 | Initialization sequence in progress |
| initStb | output | 1 | Initialization start accepted this cycle |
| cmdStb | output | 1 | Command byte written this cycle |
| cmdByte | output | 8 | Command byte |
| pollAck | output | 1 | Poll read acknowledged a level this cycle |

## Verification
Initialization is driven with three first-word patterns: cascaded with the fourth word, single without it, and single with it. Only the address-1 write count at which `initBusy` falls, and which word output captures each byte, tell these paths apart. Address-0 writes with bit patterns that differ only in bits 4, 3 and 6 separate the start, operation-word and command decodes. A rejected start pattern with bit 5 set shows that nothing is cleared. Poll reads are run with a winner and without one, and on an edge input and on a level input held high. The returned byte and the request bit left behind show which clear rule applied.

// File: rtl/irq_prog_pkg.sv
package irq_prog_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT2 = 2'd1,
    SEQ_WAIT3 = 2'd2,
    SEQ_WAIT4 = 2'd3
  } seq_t;

  typedef struct packed {
    logic ldInit;
    logic ldVec;
    logic ldCasc;
    logic ldMode;
    logic ldMask;
    logic ldOpw;
    logic cmd;
    logic pollRd;
  } strobe_t;
endpackage

// File: rtl/irq_prog_ctrl.sv
module irq_prog_ctrl
  import irq_prog_pkg::*;
#(
  parameter bit PCI_STRICT = 1'b1,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrStb,
  input  logic          rdStb,
  input  logic          addr,
  input  logic [DW-1:0] wrData,
  input  logic          singleMode,
  input  logic          needMode,
  input  logic          pollMode,
  output strobe_t       stb,
  output logic          busy
);
  seq_t seqQ, seqD;
  logic isStart, startOk;

  assign isStart = wrStb && !addr && wrData[4];
  assign startOk = isStart && !(PCI_STRICT && (wrData[7:5] != 3'b000));

  always_comb begin
    stb = '0;
    seqD = seqQ;
    stb.pollRd = rdStb && pollMode;
    if (startOk) begin
      stb.ldInit = 1'b1;
      seqD = SEQ_WAIT2;
    end else if (wrStb && !addr && !wrData[4]) begin
      if (wrData[3]) stb.ldOpw = 1'b1;
      else stb.cmd = 1'b1;
    end else if (wrStb && addr) begin
      unique case (seqQ)
        SEQ_WAIT2: begin
          stb.ldVec = 1'b1;
          if (!singleMode) seqD = SEQ_WAIT3;
          else seqD = needMode ? SEQ_WAIT4 : SEQ_IDLE;
        end
        SEQ_WAIT3: begin
          stb.ldCasc = 1'b1;
          seqD = needMode ? SEQ_WAIT4 : SEQ_IDLE;
        end
        SEQ_WAIT4: begin
          stb.ldMode = 1'b1;
          seqD = SEQ_IDLE;
        end
        default: stb.ldMask = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seqQ <= SEQ_IDLE;
    else seqQ <= seqD;
  end

  assign busy = (seqQ != SEQ_IDLE);
endmodule

// File: rtl/irq_prog_dp.sv
module irq_prog_dp
  import irq_prog_pkg::*;
#(
  parameter bit IS_SLAVE = 1'b0,
  parameter int NIN = 8,
  localparam int LW = $clog2(NIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  strobe_t        stb,
  input  logic           addr,
  input  logic [7:0]     wrData,
  input  logic [NIN-1:0] irqLines,
  input  logic [NIN-1:0] reqSet,
  input  logic [NIN-1:0] isrClr,
  input  logic           pendValid,
  input  logic [LW-1:0]  pendLevel,
  input  logic           elcrOn,
  input  logic           elcrWr,
  input  logic [NIN-1:0] elcrData,
  output logic [7:0]     rdData,
  output logic [NIN-1:0] irrQ,
  output logic [NIN-1:0] isrQ,
  output logic [NIN-1:0] imrQ,
  output logic [7:0]     w1Q,
  output logic [7:0]     w2Q,
  output logic [7:0]     w3Q,
  output logic [7:0]     w4Q,
  output logic [7:0]     opwQ,
  output logic           smmQ,
  output logic [NIN-1:0] levelTrig,
  output logic           pollHit
);
  logic [NIN-1:0] elcrQ, elcrMask, winBit, irrDrop;

  generate
    if (IS_SLAVE) begin : g_slaveMask
      assign elcrMask = ~(NIN'(1) | NIN'(32));
    end else begin : g_masterMask
      assign elcrMask = ~NIN'(7);
    end
  endgenerate

  assign levelTrig = elcrOn ? elcrQ : {NIN{w1Q[3]}};
  assign pollHit   = stb.pollRd && pendValid;
  assign winBit    = NIN'(1) << pendLevel;
  assign irrDrop   = pollHit ? (winBit & ~(levelTrig & irqLines)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irrQ <= '0; isrQ <= '0; imrQ <= '0;
      w1Q <= '0; w2Q <= '0; w3Q <= '0; w4Q <= '0;
      opwQ <= '0; smmQ <= 1'b0; elcrQ <= '0;
    end else begin
      if (elcrWr) elcrQ <= elcrData & elcrMask;
      if (stb.ldInit) begin
        w1Q  <= wrData;
        w2Q  <= '0;
        w3Q  <= '0;
        if (!wrData[0]) w4Q <= '0;
        opwQ <= '0;
        smmQ <= 1'b0;
        imrQ <= '0;
        isrQ <= '0;
        irrQ <= irqLines;
      end else begin
        irrQ <= (irrQ | reqSet) & ~irrDrop;
        isrQ <= (isrQ & ~isrClr) | (pollHit ? winBit : '0);
        if (stb.ldVec)  w2Q  <= wrData;
        if (stb.ldCasc) w3Q  <= wrData;
        if (stb.ldMode) w4Q  <= wrData;
        if (stb.ldMask) imrQ <= wrData[NIN-1:0];
        if (stb.ldOpw) begin
          opwQ <= wrData;
          if (wrData[6]) smmQ <= wrData[5];
        end else if (stb.pollRd) begin
          opwQ[2] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (stb.pollRd) rdData = pendValid ? (8'h80 | 8'(pendLevel)) : 8'h00;
    else if (addr) rdData = 8'(imrQ);
    else if (opwQ[1:0] == 2'b11) rdData = 8'(isrQ);
    else if (opwQ[1:0] == 2'b10) rdData = 8'(irrQ);
    else rdData = 8'h00;
  end
endmodule

// File: rtl/irq_prog_port.sv
module irq_prog_port
  import irq_prog_pkg::*;
#(
  parameter bit PCI_STRICT = 1'b1,
  parameter bit IS_SLAVE   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrStb,
  input  logic       rdStb,
  input  logic       addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] irqLines,
  input  logic [7:0] reqSet,
  input  logic [7:0] isrClr,
  input  logic       pendValid,
  input  logic [2:0] pendLevel,
  input  logic       elcrOn,
  input  logic       elcrWr,
  input  logic [7:0] elcrData,
  output logic [7:0] irr,
  output logic [7:0] isr,
  output logic [7:0] imr,
  output logic [7:0] initWord,
  output logic [7:0] vecBase,
  output logic [7:0] cascMap,
  output logic [7:0] modeWord,
  output logic       specialMask,
  output logic [7:0] levelTrig,
  output logic       initBusy,
  output logic       initStb,
  output logic       cmdStb,
  output logic [7:0] cmdByte,
  output logic       pollAck
);
  strobe_t stb;
  logic [7:0] opw;
  logic pollMode;

  assign pollMode = opw[2];

  irq_prog_ctrl #(.PCI_STRICT(PCI_STRICT), .DW(8)) u_ctrl (
    .clk(clk), .rst(rst), .wrStb(wrStb), .rdStb(rdStb), .addr(addr),
    .wrData(wrData), .singleMode(initWord[1]), .needMode(initWord[0]),
    .pollMode(pollMode), .stb(stb), .busy(initBusy)
  );

  irq_prog_dp #(.IS_SLAVE(IS_SLAVE), .NIN(8)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .addr(addr), .wrData(wrData),
    .irqLines(irqLines), .reqSet(reqSet), .isrClr(isrClr),
    .pendValid(pendValid), .pendLevel(pendLevel), .elcrOn(elcrOn),
    .elcrWr(elcrWr), .elcrData(elcrData), .rdData(rdData),
    .irrQ(irr), .isrQ(isr), .imrQ(imr), .w1Q(initWord), .w2Q(vecBase),
    .w3Q(cascMap), .w4Q(modeWord), .opwQ(opw), .smmQ(specialMask),
    .levelTrig(levelTrig), .pollHit(pollAck)
  );

  assign initStb = stb.ldInit;
  assign cmdStb  = stb.cmd;
  assign cmdByte = wrData;
endmodule

// File: rtl/irq_prog_port_chk.sv
module irq_prog_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrStb,
  input logic       rdStb,
  input logic       addr,
  input logic [7:0] wrData,
  input logic [7:0] irqLines,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [7:0] irr,
  input logic       initBusy,
  input logic       specialMask,
  input logic       cmdStb,
  input logic       pollMode
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (imr == 8'h00 && isr == 8'h00 && irr == 8'h00 && !initBusy && !specialMask));

  // R2
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    (wrStb && !addr && wrData[4] && wrData[7:5] == 3'b000)
      |=> (initBusy && imr == 8'h00 && isr == 8'h00 && !specialMask && irr == $past(irqLines)));

  // R4
  a_r4_mask_held_in_init: assert property (@(posedge clk) disable iff (rst)
    (initBusy && wrStb && addr) |=> $stable(imr));

  // R6
  a_r6_cmd_keeps_mask: assert property (@(posedge clk) disable iff (rst)
    cmdStb |=> ($stable(imr) && $stable(specialMask)));

  // R7
  a_r7_poll_once: assert property (@(posedge clk) disable iff (rst)
    (rdStb && pollMode && !wrStb) |=> !pollMode);

  // R10
  a_r10_reject_start: assert property (@(posedge clk) disable iff (rst)
    (!initBusy && wrStb && !addr && wrData[4] && wrData[7:5] != 3'b000) |=> (!initBusy && $stable(imr)));
endmodule

bind irq_prog_port irq_prog_port_chk u_chk (
  .clk(clk), .rst(rst), .wrStb(wrStb), .rdStb(rdStb), .addr(addr),
  .wrData(wrData), .irqLines(irqLines), .imr(imr), .isr(isr), .irr(irr),
  .initBusy(initBusy), .specialMask(specialMask), .cmdStb(cmdStb),
  .pollMode(pollMode)
);

// File: tb/irq_prog_port_test.sv
module irq_prog_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrStb = 1'b0, rdStb = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0, irqLines = '0, reqSet = '0, isrClr = '0, elcrData = '0;
  logic pendValid = 1'b0, elcrOn = 1'b0, elcrWr = 1'b0;
  logic [2:0] pendLevel = '0;
  logic [7:0] rdData, irr, isr, imr, initWord, vecBase, cascMap, modeWord, levelTrig, cmdByte;
  logic specialMask, initBusy, initStb, cmdStb, pollAck;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  irq_prog_port uut (
    .clk(clk), .rst(rst), .wrStb(wrStb), .rdStb(rdStb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqLines(irqLines), .reqSet(reqSet), .isrClr(isrClr),
    .pendValid(pendValid), .pendLevel(pendLevel), .elcrOn(elcrOn), .elcrWr(elcrWr),
    .elcrData(elcrData), .irr(irr), .isr(isr), .imr(imr), .initWord(initWord),
    .vecBase(vecBase), .cascMap(cascMap), .modeWord(modeWord), .specialMask(specialMask),
    .levelTrig(levelTrig), .initBusy(initBusy), .initStb(initStb), .cmdStb(cmdStb),
    .cmdByte(cmdByte), .pollAck(pollAck)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk); wrStb = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrStb = 1'b0; wrData = '0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    @(negedge clk); rdStb = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 imr", imr, 8'h00);
    check("R1 irr", irr, 8'h00);
    check("R1 isr", isr, 8'h00);
    check("R1 busy", {7'b0, initBusy}, 8'h00);
    busRead(1'b1, d);
    check("R1 read mask", d, 8'h00);
  endtask

  task automatic t_initCascade();
    irqLines = 8'h24;
    @(negedge clk); wrStb = 1'b1; addr = 1'b0; wrData = 8'h11;
    #1 check("R2 initStb", {7'b0, initStb}, 8'h01);
    @(negedge clk); wrStb = 1'b0;
    check("R2 busy", {7'b0, initBusy}, 8'h01);
    check("R2 irr from lines", irr, 8'h24);
    irqLines = 8'h00;
    busWrite(1'b1, 8'h08);
    check("R3 vec", vecBase, 8'h08);
    check("R3 wait casc", {7'b0, initBusy}, 8'h01);
    busWrite(1'b1, 8'h04);
    check("R3 casc", cascMap, 8'h04);
    check("R3 wait mode", {7'b0, initBusy}, 8'h01);
    busWrite(1'b1, 8'h01);
    check("R3 mode", modeWord, 8'h01);
    check("R3 idle", {7'b0, initBusy}, 8'h00);
    check("R4 mask untouched by init", imr, 8'h00);
    busWrite(1'b1, 8'hF0);
    check("R4 mask load", imr, 8'hF0);
  endtask

  task automatic t_initSingle();
    busWrite(1'b0, 8'h12);
    check("R2 mask cleared", imr, 8'h00);
    check("R2 mode cleared", modeWord, 8'h00);
    busWrite(1'b1, 8'h40);
    check("R3 single idle", {7'b0, initBusy}, 8'h00);
    check("R3 casc cleared", cascMap, 8'h00);
    busWrite(1'b1, 8'h3C);
    check("R4 mask", imr, 8'h3C);
  endtask

  task automatic t_initSingleMode();
    busWrite(1'b0, 8'h13);
    busWrite(1'b1, 8'h20);
    check("R3 skip casc", {7'b0, initBusy}, 8'h01);
    busWrite(1'b1, 8'h03);
    check("R3 mode word", modeWord, 8'h03);
    check("R3 casc stays 0", cascMap, 8'h00);
    check("R3 idle after mode", {7'b0, initBusy}, 8'h00);
    busWrite(1'b1, 8'h3C);
  endtask

  task automatic t_reject();
    busWrite(1'b0, 8'h30);
    check("R10 still idle", {7'b0, initBusy}, 8'h00);
    check("R10 mask kept", imr, 8'h3C);
    check("R10 word kept", initWord, 8'h13);
  endtask

  task automatic t_opw();
    busWrite(1'b0, 8'h68);
    check("R5 smm set", {7'b0, specialMask}, 8'h01);
    busWrite(1'b0, 8'h28);
    check("R5 smm kept", {7'b0, specialMask}, 8'h01);
    busWrite(1'b0, 8'h48);
    check("R5 smm clear", {7'b0, specialMask}, 8'h00);
  endtask

  task automatic t_cmd();
    @(negedge clk); wrStb = 1'b1; addr = 1'b0; wrData = 8'h20;
    #1 check("R6 cmdStb", {7'b0, cmdStb}, 8'h01);
    check("R6 cmdByte", cmdByte, 8'h20);
    @(negedge clk); wrStb = 1'b0;
    check("R6 mask kept", imr, 8'h3C);
  endtask

  task automatic t_reads();
    logic [7:0] d;
    @(negedge clk); reqSet = 8'h81;
    @(negedge clk); reqSet = 8'h00;
    check("R13 req set", irr, 8'h81);
    busWrite(1'b0, 8'h0A);
    busRead(1'b0, d);
    check("R9 read irr", d, 8'h81);
    busWrite(1'b0, 8'h0B);
    busRead(1'b0, d);
    check("R9 read isr", d, 8'h00);
    busWrite(1'b0, 8'h08);
    busRead(1'b0, d);
    check("R9 read none", d, 8'h00);
    busRead(1'b1, d);
    check("R9 read mask", d, 8'h3C);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    pendValid = 1'b1; pendLevel = 3'd7;
    busWrite(1'b0, 8'h0C);
    @(negedge clk); rdStb = 1'b1; addr = 1'b0;
    #1 d = rdData;
    check("R7 pollAck", {7'b0, pollAck}, 8'h01);
    @(negedge clk); rdStb = 1'b0;
    check("R7 poll byte", d, 8'h87);
    check("R7 isr set", isr, 8'h80);
    check("R7 irr edge drop", irr, 8'h01);
    busRead(1'b0, d);
    check("R7 poll bit cleared", d, 8'h00);
    pendValid = 1'b0;
    busWrite(1'b0, 8'h0C);
    busRead(1'b0, d);
    check("R7 empty poll", d, 8'h00);
    check("R7 isr unchanged", isr, 8'h80);
    @(negedge clk); isrClr = 8'h80;
    @(negedge clk); isrClr = 8'h00;
    check("R13 isr clear", isr, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    elcrOn = 1'b1;
    @(negedge clk); elcrWr = 1'b1; elcrData = 8'hFF;
    @(negedge clk); elcrWr = 1'b0;
    check("R11 master mask", levelTrig, 8'hF8);
    elcrOn = 1'b0; #1;
    check("R12 global edge", levelTrig, 8'h00);
    elcrOn = 1'b1;
    irqLines = 8'h08;
    @(negedge clk); reqSet = 8'h08;
    @(negedge clk); reqSet = 8'h00;
    pendValid = 1'b1; pendLevel = 3'd3;
    busWrite(1'b0, 8'h0C);
    busRead(1'b0, d);
    check("R7 poll level3", d, 8'h83);
    check("R8 level irr kept", irr, 8'h09);
    pendLevel = 3'd0;
    busWrite(1'b0, 8'h0C);
    busRead(1'b0, d);
    check("R7 poll level0", d, 8'h80);
    check("R8 forced-edge drop", irr, 8'h08);
    check("R8 isr", isr, 8'h09);
    pendValid = 1'b0;
    busWrite(1'b0, 8'h1A);
    elcrOn = 1'b0; #1;
    check("R12 global level", levelTrig, 8'hFF);
    check("R2 irr reload", irr, 8'h08);
    check("R2 isr cleared", isr, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_initCascade();
        t_initSingle();
        t_initSingleMode();
        t_reject();
        t_opw();
        t_cmd();
        t_reads();
        t_poll();
        t_level();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule